// File: doc/BRIEF.md
# Gated Master/Slave Timer Pair

This block holds two identical timer units, a master and a slave, reached over a narrow 4-bit data bus. Each unit has a slow counter and a fast counter. The slow counter is 4 bits wide and advances on a slow tick-enable input. The fast counter is 32 bits wide and advances on a fast tick-enable input. Both tick inputs are one-cycle enables in the system clock domain, not separate clocks. Software reads each counter, and may also overwrite it, one nibble at a time through a 16-nibble counter window. Each unit also has a 16-nibble control window that holds one run-control nibble per counter.

The slave unit is subordinate to the master. A slave counter can advance only while the matching master counter is enabled. Stopping a master counter therefore freezes the slave counter of the same kind, even when the slave's own enable stays set. In normal use the master fast counter runs all the time as a system tick. The slave counters stay stopped until software needs them, for example to produce a blink rate. Each counter emits a one-cycle pulse when it rolls over from all ones to zero.

Top module: `dual_rate_timer_pair`

## Requirements
- R1: After reset, every counter reads zero, every control nibble reads zero and all rollover pulses are low.
- R2: In the counter window (bus_space=1), offset 7 holds the 4-bit slow counter. The slow counter adds one in the clock edge after a cycle with tick_slow high, provided bit 0 of the control nibble at offset E of the control window (bus_space=0) is set.
- R3: Offsets 8 to F of the counter window hold the 32-bit fast counter, with offset 8 as the least significant nibble. The fast counter adds one per tick_fast cycle, provided bit 0 of the control nibble at offset F is set.
- R4: Control nibbles read back all four bits exactly as written. Only bit 0 has any effect; a control value with bit 0 clear stops the counter whatever bits 3..1 hold.
- R5: A slave counter (bus_unit=1) advances only while bit 0 of the master (bus_unit=0) control nibble of the same kind is set.
- R6: A counter at all ones that takes an increment becomes zero. Its rollover output (index 0 master, 1 slave) is high for exactly the one cycle in which the zero value is visible.
- R7: A counter nibble write replaces that nibble only. If an increment lands in the same cycle, the written nibble takes the written value and the other nibbles take their incremented values.
- R8: Offsets that hold neither a counter nor a control nibble read as zero, and writes to them change no visible state.
- R9: bus_unit selects the unit for both reads and writes. A write to one unit never alters the registers of the other unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_slow | input | 1 | One-cycle enable for the slow counters |
| tick_fast | input | 1 | One-cycle enable for the fast counters |
| bus_we | input | 1 | Nibble write strobe |
| bus_unit | input | 1 | Unit select: 0 master, 1 slave |
| bus_space | input | 1 | Window select: 0 control, 1 counters |
| bus_addr | input | 4 | Nibble offset in the selected window |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble, combinational from the address |
| t1_wrap | output | 2 | Slow-counter rollover pulses (bit 0 master, bit 1 slave) |
| t2_wrap | output | 2 | Fast-counter rollover pulses (bit 0 master, bit 1 slave) |

## Verification
The assertions check several properties on every clock. A master fast counter steps by exactly one on an enabled tick with no write. Both slave counters hold still while their master enable is clear and no slave counter write occurs. All counters hold when there is neither a tick nor a write. A rollover pulse only follows an all-ones value.

Other behaviour is shown only by the bench scenarios. These are the nibble order of the 32-bit value, write-wins merging with a simultaneous increment, and the read-back of control bits 3..1 without effect. They also include zero reads of unmapped offsets and the separation between the two units.

// File: rtl/dtp_pkg.sv
// Shared constants for the gated timer pair: window geometry and the
// offsets of the control nibbles inside a unit's control window.
package dtp_pkg;
    localparam int NIB_W       = 4;             // bus data width
    localparam int ADDR_W      = 4;             // nibble offset width
    localparam int WINDOW      = 1 << ADDR_W;   // nibbles per window
    localparam int CTL_T1_OFS  = 14;            // slow counter control
    localparam int CTL_T2_OFS  = 15;            // fast counter control
    localparam logic SPACE_CTL = 1'b0;
    localparam logic SPACE_CNT = 1'b1;
endpackage

// File: rtl/nibble_counter.sv
// Up-counter of NIBBLES nibbles with per-nibble overwrite.
// Assumes: a write to one nibble beats the increment for that nibble only;
// the rollover pulse is registered and lines up with the zero value.
module nibble_counter #(
    parameter int NIBBLES = 8,
    localparam int W      = NIBBLES * dtp_pkg::NIB_W,
    localparam int IDX_W  = (NIBBLES > 1) ? $clog2(NIBBLES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [dtp_pkg::NIB_W-1:0] wr_data,
    output logic [W-1:0]              value,
    output logic                      wrap
);
    logic [W-1:0] nxt;

    // Next value: increment first, then overlay the written nibble.
    always_comb begin
        nxt = inc ? value + W'(1) : value;
        for (int k = 0; k < NIBBLES; k++) begin
            if (wr_en && wr_idx == IDX_W'(k))
                nxt[k*dtp_pkg::NIB_W +: dtp_pkg::NIB_W] = wr_data;
        end
    end

    // State and rollover pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
            wrap  <= 1'b0;
        end else begin
            value <= nxt;
            wrap  <= inc && (value == {W{1'b1}});
        end
    end
endmodule

// File: rtl/timer_unit.sv
// One timer unit: two control nibbles, a slow and a fast counter, and the
// read multiplexer of its two windows.
// Assumes: the fast counter fills the top of the counter window and the
// slow counter sits directly below it; gate inputs come from the master.
module timer_unit #(
    parameter int T1_NIBBLES = 1,
    parameter int T2_NIBBLES = 8,
    localparam int T2_BASE   = dtp_pkg::WINDOW - T2_NIBBLES,
    localparam int T1_BASE   = T2_BASE - T1_NIBBLES,
    localparam int T1_W      = T1_NIBBLES * dtp_pkg::NIB_W,
    localparam int T2_W      = T2_NIBBLES * dtp_pkg::NIB_W,
    localparam int I1_W      = (T1_NIBBLES > 1) ? $clog2(T1_NIBBLES) : 1,
    localparam int I2_W      = (T2_NIBBLES > 1) ? $clog2(T2_NIBBLES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_slow,
    input  logic                        tick_fast,
    input  logic                        gate_t1,
    input  logic                        gate_t2,
    input  logic                        wr_en,
    input  logic                        space,
    input  logic [dtp_pkg::ADDR_W-1:0]  addr,
    input  logic [dtp_pkg::NIB_W-1:0]   wdata,
    output logic [dtp_pkg::NIB_W-1:0]   rdata,
    output logic                        run_t1,
    output logic                        run_t2,
    output logic [T1_W-1:0]             t1_value,
    output logic [T2_W-1:0]             t2_value,
    output logic                        t1_wrap,
    output logic                        t2_wrap
);
    import dtp_pkg::*;

    logic [NIB_W-1:0] ctl_t1, ctl_t2;
    logic             t1_hit, t2_hit;
    logic [I1_W-1:0]  t1_idx;
    logic [I2_W-1:0]  t2_idx;

    // Control nibble registers, written through the control window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_t1 <= '0;
            ctl_t2 <= '0;
        end else if (wr_en && space == SPACE_CTL) begin
            if (addr == ADDR_W'(CTL_T1_OFS)) ctl_t1 <= wdata;
            if (addr == ADDR_W'(CTL_T2_OFS)) ctl_t2 <= wdata;
        end
    end

    // Only bit 0 of each control nibble runs its counter.
    assign run_t1 = ctl_t1[0];
    assign run_t2 = ctl_t2[0];

    // Counter window write decode.
    assign t1_hit = wr_en && space == SPACE_CNT &&
                    addr >= ADDR_W'(T1_BASE) && addr < ADDR_W'(T2_BASE);
    assign t2_hit = wr_en && space == SPACE_CNT && addr >= ADDR_W'(T2_BASE);
    assign t1_idx = I1_W'(addr - ADDR_W'(T1_BASE));
    assign t2_idx = I2_W'(addr - ADDR_W'(T2_BASE));

    nibble_counter #(.NIBBLES(T1_NIBBLES)) u_slow (
        .clk(clk), .rst_n(rst_n),
        .inc(tick_slow && run_t1 && gate_t1),
        .wr_en(t1_hit), .wr_idx(t1_idx), .wr_data(wdata),
        .value(t1_value), .wrap(t1_wrap)
    );

    nibble_counter #(.NIBBLES(T2_NIBBLES)) u_fast (
        .clk(clk), .rst_n(rst_n),
        .inc(tick_fast && run_t2 && gate_t2),
        .wr_en(t2_hit), .wr_idx(t2_idx), .wr_data(wdata),
        .value(t2_value), .wrap(t2_wrap)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (space == SPACE_CTL) begin
            if (addr == ADDR_W'(CTL_T1_OFS)) rdata = ctl_t1;
            if (addr == ADDR_W'(CTL_T2_OFS)) rdata = ctl_t2;
        end else begin
            for (int k = 0; k < T1_NIBBLES; k++)
                if (addr == ADDR_W'(T1_BASE + k)) rdata = t1_value[k*NIB_W +: NIB_W];
            for (int k = 0; k < T2_NIBBLES; k++)
                if (addr == ADDR_W'(T2_BASE + k)) rdata = t2_value[k*NIB_W +: NIB_W];
        end
    end
endmodule

// File: rtl/dual_rate_timer_pair.sv
// Top of the timer pair: a master and a slave timer unit on one nibble bus.
// Assumes: each slave counter is gated by the run bit of the master counter
// of the same kind; the master is never gated.
module dual_rate_timer_pair #(
    parameter int T1_NIBBLES = 1,
    parameter int T2_NIBBLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_slow,
    input  logic       tick_fast,
    input  logic       bus_we,
    input  logic       bus_unit,
    input  logic       bus_space,
    input  logic [3:0] bus_addr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata,
    output logic [1:0] t1_wrap,
    output logic [1:0] t2_wrap
);
    localparam int NUNITS = 2;
    localparam int T1_W   = T1_NIBBLES * dtp_pkg::NIB_W;
    localparam int T2_W   = T2_NIBBLES * dtp_pkg::NIB_W;

    logic [NUNITS-1:0]           run_t1, run_t2;
    logic [NUNITS-1:0][3:0]      unit_rdata;
    logic [NUNITS-1:0][T1_W-1:0] t1_val;
    logic [NUNITS-1:0][T2_W-1:0] t2_val;

    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
        logic gate1, gate2;
        // Unit 0 runs freely; unit 1 follows the master run bits.
        assign gate1 = (u == 0) ? 1'b1 : run_t1[0];
        assign gate2 = (u == 0) ? 1'b1 : run_t2[0];

        timer_unit #(.T1_NIBBLES(T1_NIBBLES), .T2_NIBBLES(T2_NIBBLES)) u_tu (
            .clk(clk), .rst_n(rst_n),
            .tick_slow(tick_slow), .tick_fast(tick_fast),
            .gate_t1(gate1), .gate_t2(gate2),
            .wr_en(bus_we && bus_unit == 1'(u)),
            .space(bus_space), .addr(bus_addr), .wdata(bus_wdata),
            .rdata(unit_rdata[u]),
            .run_t1(run_t1[u]), .run_t2(run_t2[u]),
            .t1_value(t1_val[u]), .t2_value(t2_val[u]),
            .t1_wrap(t1_wrap[u]), .t2_wrap(t2_wrap[u])
        );
    end

    // Read data from the selected unit.
    assign bus_rdata = unit_rdata[bus_unit];
endmodule

// File: rtl/dtp_checker.sv
// Temporal checks on the timer pair, attached to the top by bind.
module dtp_checker #(
    parameter int T1_W = 4,
    parameter int T2_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_slow,
    input logic                 tick_fast,
    input logic                 bus_we,
    input logic                 bus_unit,
    input logic                 bus_space,
    input logic [1:0]           run_t1,
    input logic [1:0]           run_t2,
    input logic [1:0][T1_W-1:0] t1_val,
    input logic [1:0][T2_W-1:0] t2_val,
    input logic [1:0]           t1_wrap,
    input logic [1:0]           t2_wrap
);
    AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_fast && run_t2[0] && !bus_we) |=> t2_val[0] == $past(t2_val[0]) + T2_W'(1)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_fast && !tick_slow && !bus_we) |=> ($stable(t1_val) && $stable(t2_val))); // R2

    AST_SLAVE_FAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_t2[0] && !(bus_we && bus_unit && bus_space)) |=> $stable(t2_val[1])); // R5

    AST_SLAVE_SLOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_t1[0] && !(bus_we && bus_unit && bus_space)) |=> $stable(t1_val[1])); // R5

    AST_FAST_WRAP_M: assert property (@(posedge clk) disable iff (!rst_n)
        t2_wrap[0] |-> $past(t2_val[0]) == {T2_W{1'b1}}); // R6

    AST_FAST_WRAP_S: assert property (@(posedge clk) disable iff (!rst_n)
        t2_wrap[1] |-> $past(t2_val[1]) == {T2_W{1'b1}}); // R6

    AST_SLOW_WRAP_M: assert property (@(posedge clk) disable iff (!rst_n)
        t1_wrap[0] |-> $past(t1_val[0]) == {T1_W{1'b1}}); // R6
endmodule

bind dual_rate_timer_pair dtp_checker #(
    .T1_W(T1_NIBBLES * 4), .T2_W(T2_NIBBLES * 4)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_we(bus_we), .bus_unit(bus_unit), .bus_space(bus_space),
    .run_t1(run_t1), .run_t2(run_t2), .t1_val(t1_val), .t2_val(t2_val),
    .t1_wrap(t1_wrap), .t2_wrap(t2_wrap)
);

// File: tb/dual_rate_timer_pair_test.sv
module dual_rate_timer_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_slow = 1'b0, tick_fast = 1'b0;
    logic       bus_we = 1'b0, bus_unit = 1'b0, bus_space = 1'b0;
    logic [3:0] bus_addr = '0, bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic [1:0] t1_wrap, t2_wrap;

    int errors = 0;
    int checks = 0;

    bit [3:0]  m_c1 [2];
    bit [3:0]  m_c2 [2];
    bit [3:0]  m_t1 [2];
    bit [31:0] m_t2 [2];

    dual_rate_timer_pair uut (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .bus_we(bus_we), .bus_unit(bus_unit), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .t1_wrap(t1_wrap), .t2_wrap(t2_wrap)
    );

    always #5 clk = ~clk;

    function automatic bit [3:0] exp_read(bit u, bit sp, bit [3:0] a);
        if (!sp) return (a == 4'hE) ? m_c1[u] : (a == 4'hF) ? m_c2[u] : 4'h0;
        if (a == 4'h7) return m_t1[u];
        if (a >= 4'h8) return m_t2[u][(int'(a) - 8) * 4 +: 4];
        return 4'h0;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus; the model advances and rollover pulses are checked.
    task automatic step(bit ts, bit tf, bit we, bit u, bit sp, bit [3:0] a, bit [3:0] wd);
        bit [1:0] w1, w2;
        @(negedge clk);
        tick_slow = ts; tick_fast = tf; bus_we = we;
        bus_unit = u; bus_space = sp; bus_addr = a; bus_wdata = wd;
        for (int k = 0; k < 2; k++) begin
            bit i1, i2;
            i1 = ts && m_c1[k][0] && (k == 0 || m_c1[0][0]);
            i2 = tf && m_c2[k][0] && (k == 0 || m_c2[0][0]);
            w1[k] = i1 && m_t1[k] == 4'hF;
            w2[k] = i2 && m_t2[k] == 32'hFFFF_FFFF;
            m_t1[k] = m_t1[k] + 4'(i1);
            m_t2[k] = m_t2[k] + 32'(i2);
        end
        if (we) begin
            if (!sp) begin
                if (a == 4'hE) m_c1[u] = wd;
                if (a == 4'hF) m_c2[u] = wd;
            end else if (a == 4'h7) m_t1[u] = wd;
            else if (a >= 4'h8) m_t2[u][(int'(a) - 8) * 4 +: 4] = wd;
        end
        @(posedge clk);
        #1;
        check(t1_wrap == w1, "R6", "slow rollover", t1_wrap, w1);
        check(t2_wrap == w2, "R6", "fast rollover", t2_wrap, w2);
    endtask

    // Idle cycles reading every offset of every window of both units.
    task automatic verify_all(string tag);
        for (int u = 0; u < 2; u++)
            for (int sp = 0; sp < 2; sp++)
                for (int a = 0; a < 16; a++) begin
                    bit [3:0] e;
                    @(negedge clk);
                    tick_slow = 0; tick_fast = 0; bus_we = 0;
                    bus_unit = 1'(u); bus_space = 1'(sp); bus_addr = 4'(a);
                    #1;
                    e = exp_read(1'(u), 1'(sp), 4'(a));
                    check(bus_rdata == e, tag, $sformatf("read u%0d s%0d @%0h", u, sp, a),
                          bus_rdata, e);
                end
    endtask

    task automatic write_t2(bit u, bit [31:0] v);
        for (int n = 0; n < 8; n++) step(0, 0, 1, u, 1, 4'(8 + n), v[n*4 +: 4]);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check(t1_wrap == 2'b00 && t2_wrap == 2'b00, "R1", "wraps after reset",
              {t1_wrap, t2_wrap}, 0);
        @(negedge clk) rst_n = 1'b1;
        verify_all("R1");

        // R3: master fast counter, LSB-first nibble layout and stepping.
        write_t2(0, 32'h1234_5678);
        step(0, 0, 1, 0, 0, 4'hF, 4'h1);
        repeat (5) step(0, 1, 0, 0, 0, 0, 0);
        verify_all("R3");

        // R4: upper control bits read back but do not run the counter.
        step(0, 0, 1, 0, 0, 4'hF, 4'hE);
        repeat (4) step(0, 1, 0, 0, 0, 0, 0);
        verify_all("R4");

        // R5: slave enabled, master stopped: slave frozen; then master on.
        step(0, 0, 1, 1, 0, 4'hF, 4'h1);
        step(0, 0, 1, 1, 0, 4'hE, 4'h1);
        repeat (6) step(1, 1, 0, 0, 0, 0, 0);
        verify_all("R5");
        step(0, 0, 1, 0, 0, 4'hF, 4'h1);
        step(0, 0, 1, 0, 0, 4'hE, 4'h1);
        repeat (6) step(1, 1, 0, 0, 0, 0, 0);
        verify_all("R5");

        // R6: fast rollover on both units, slow rollover via slow ticks.
        write_t2(0, 32'hFFFF_FFFF);
        write_t2(1, 32'hFFFF_FFFE);
        step(0, 1, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        repeat (20) step(1, 0, 0, 0, 0, 0, 0);
        verify_all("R6");

        // R7: write to nibble 0 in the same cycle as an increment.
        write_t2(0, 32'h0000_000F);
        step(0, 1, 1, 0, 1, 4'h8, 4'h5);
        step(1, 1, 1, 1, 1, 4'h7, 4'hA);
        verify_all("R7");

        // R8: writes to unmapped offsets leave everything unchanged.
        step(0, 0, 1, 0, 1, 4'h3, 4'hF);
        step(0, 0, 1, 1, 0, 4'h2, 4'hF);
        step(0, 0, 1, 0, 0, 4'h7, 4'hF);
        verify_all("R8");

        // R9: constrained random mix of ticks, writes and control changes.
        for (int i = 0; i < 2000; i++) begin
            bit [3:0] a, d;
            a = 4'($urandom_range(0, 15));
            d = ($urandom_range(0, 1) != 0) ? 4'hF : 4'($urandom);
            step($urandom_range(0, 3) == 0, $urandom_range(0, 1) != 0,
                 $urandom_range(0, 2) == 0, 1'($urandom), 1'($urandom), a, d);
            if (i % 40 == 39) verify_all("R9");
        end
        verify_all("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule